// File: doc/BRIEF.md
# Rotate-Right Unit for a 64-bit Datapath

This block rotates a 64-bit operand to the right. It has two widths. A word rotate acts on the lower half of the source, and its 32-bit result is sign-extended to fill the full output. A doubleword rotate acts on all 64 bits. The rotate amount comes from a 5-bit immediate field or from the low bits of a second register operand. A third immediate form of the doubleword rotate adds 32 to the immediate, so immediate rotates can cover the upper half of the range.

The unit is purely combinational and holds no state. An execute stage drives the source, both amount sources and a 3-bit operation code. It takes the 64-bit result in the same cycle.

Top module: `rotr_unit`

## Requirements
- R1: The 3-bit `op_i` selects the operation: 0 is a word rotate by immediate, 1 is a word rotate by register, 2 is a doubleword rotate by immediate, 3 is a doubleword rotate by register, and 4 is a doubleword rotate by immediate plus 32.
- R2: A word rotate (codes 0 and 1) rotates `src_i[31:0]` right by the amount modulo 32. It then copies bit 31 of that rotated word into `res_o[63:32]`.
- R3: In a word rotate, `src_i[63:32]` has no effect on `res_o`.
- R4: A doubleword rotate (codes 2 and 3) rotates all 64 bits of `src_i` right by the amount modulo 64.
- R5: Code 4 rotates the 64-bit source right by `imm_i + 32`.
- R6: The register forms (codes 1 and 3) take the amount from `amt_i`. Code 1 uses only bits [4:0] and code 3 uses only bits [5:0]. `imm_i` is ignored in the register forms, and `amt_i` is ignored in the immediate forms.
- R7: When the effective amount is zero, the source passes through unchanged. In word mode the sign extension still applies.
- R8: The unused codes 5, 6 and 7 return `src_i` unchanged.
- R9: The output depends only on the present inputs. When all inputs are zero, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Operand to rotate |
| imm_i | input | 5 | Immediate rotate amount |
| amt_i | input | 64 | Register operand holding the rotate amount |
| op_i | input | 3 | Operation code |
| res_o | output | 64 | Rotated result |

## Verification
Every result is due in the same cycle as its stimulus, with no register on the path. The bench therefore drives each input set just after a rising clock edge and samples `res_o` at the following falling edge, half a period later. The input set is then held until the next rising edge, so each sample reflects only the inputs applied in that cycle.

// File: rtl/rotr_pkg.sv
package rotr_pkg;
   typedef enum logic [2:0] {
      OP_W_IMM  = 3'd0,
      OP_W_REG  = 3'd1,
      OP_D_IMM  = 3'd2,
      OP_D_REG  = 3'd3,
      OP_D_IMMH = 3'd4
   } rot_op_e;
endpackage

// File: rtl/rotr_amount_sel.sv
module rotr_amount_sel
   import rotr_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 5
) (
   input  logic [IMM_W-1:0]          imm_i,
   input  logic [DATA_W-1:0]         amt_i,
   input  logic [2:0]                op_i,
   output logic [$clog2(DATA_W)-1:0] sh_o,
   output logic                      word_o,
   output logic                      pass_o
);
   localparam int SH_W = $clog2(DATA_W);

   initial begin
      if (IMM_W != SH_W - 1) $error("IMM_W must cover half the data width");
   end

   always_comb begin
      sh_o   = '0;
      word_o = 1'b0;
      pass_o = 1'b0;
      case (rot_op_e'(op_i))
         OP_W_IMM:  begin sh_o = {1'b0, imm_i};            word_o = 1'b1; end
         OP_W_REG:  begin sh_o = {1'b0, amt_i[IMM_W-1:0]}; word_o = 1'b1; end
         OP_D_IMM:  sh_o = {1'b0, imm_i};
         OP_D_REG:  sh_o = amt_i[SH_W-1:0];
         OP_D_IMMH: sh_o = {1'b1, imm_i};
         default:   pass_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/rotr_barrel.sv
module rotr_barrel #(
   parameter int W      = 64,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]         din_i,
   input  logic [$clog2(W)-1:0] sh_i,
   output logic [W-1:0]         dout_o
);
   localparam int SW = $clog2(W);

   initial begin
      if ((1 << SW) != W) $error("rotate width must be a power of two");
   end

   generate
      if (STAGED) begin : g_log
         logic [W-1:0] st [0:SW];
         assign st[0] = din_i;
         for (genvar k = 0; k < SW; k++) begin : g_stage
            localparam int D = 1 << k;
            assign st[k+1] = sh_i[k] ? {st[k][D-1:0], st[k][W-1:D]} : st[k];
         end
         assign dout_o = st[SW];
      end else begin : g_flat
         logic [2*W-1:0] dbl;
         assign dbl    = {din_i, din_i} >> sh_i;
         assign dout_o = dbl[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rotr_widen.sv
module rotr_widen #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 64
) (
   input  logic [IN_W-1:0]  din_i,
   output logic [OUT_W-1:0] dout_o
);
   initial begin
      if (OUT_W <= IN_W) $error("widen target must be wider than source");
   end
   assign dout_o = {{(OUT_W-IN_W){din_i[IN_W-1]}}, din_i};
endmodule

// File: rtl/rotr_unit.sv
module rotr_unit #(
   parameter int DATA_W = 64,
   parameter bit STAGED = 1'b1
) (
   input  logic [DATA_W-1:0]           src_i,
   input  logic [$clog2(DATA_W)-2:0]   imm_i,
   input  logic [DATA_W-1:0]           amt_i,
   input  logic [2:0]                  op_i,
   output logic [DATA_W-1:0]           res_o
);
   localparam int SH_W   = $clog2(DATA_W);
   localparam int HALF_W = DATA_W / 2;
   localparam int IMM_W  = SH_W - 1;

   initial begin
      if (DATA_W < 4 || (1 << SH_W) != DATA_W) $error("DATA_W must be a power of two >= 4");
   end

   logic [SH_W-1:0]   sh;
   logic              word_m, pass_m;
   logic [HALF_W-1:0] rot_w;
   logic [DATA_W-1:0] rot_d, ext_w;

   rotr_amount_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_amt (
      .imm_i(imm_i), .amt_i(amt_i), .op_i(op_i),
      .sh_o(sh), .word_o(word_m), .pass_o(pass_m)
   );

   rotr_barrel #(.W(HALF_W), .STAGED(STAGED)) u_rot_w (
      .din_i(src_i[HALF_W-1:0]), .sh_i(sh[SH_W-2:0]), .dout_o(rot_w)
   );

   rotr_barrel #(.W(DATA_W), .STAGED(STAGED)) u_rot_d (
      .din_i(src_i), .sh_i(sh), .dout_o(rot_d)
   );

   rotr_widen #(.IN_W(HALF_W), .OUT_W(DATA_W)) u_ext (
      .din_i(rot_w), .dout_o(ext_w)
   );

   always_comb begin
      if (pass_m)      res_o = src_i;
      else if (word_m) res_o = ext_w;
      else             res_o = rot_d;
   end

   always_comb begin
      // R2
      word_sext_chk: assert (!word_m || res_o[DATA_W-1:HALF_W] == {HALF_W{rot_w[HALF_W-1]}});
      // R2
      word_bits_chk: assert (!word_m || $countones(res_o[HALF_W-1:0]) == $countones(src_i[HALF_W-1:0]));
      // R4
      dword_bits_chk: assert (word_m || $countones(res_o) == $countones(src_i));
      // R7
      zero_pass_chk: assert (word_m || sh != '0 || res_o == src_i);
      // R5
      hi_offset_chk: assert (op_i != 3'd4 || res_o == {src_i[HALF_W-1:0], src_i[DATA_W-1:HALF_W]} || imm_i != '0);
   end
endmodule

// File: tb/tb_rotr_unit.sv
module tb_rotr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src, amt, res;
   logic [4:0]  imm;
   logic [2:0]  op;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   rotr_unit dut (.src_i(src), .imm_i(imm), .amt_i(amt), .op_i(op), .res_o(res));

   localparam logic [63:0] S = 64'h0123_4567_89AB_CDEF;
   localparam int NV = 17;
   // {op, imm, amt, src, expected}
   localparam logic [199:0] VEC [0:NV-1] = '{
      {3'd0, 5'd4,  64'h3,  S, 64'hFFFF_FFFF_F89A_BCDE},           // R1 R2
      {3'd0, 5'd0,  64'h7,  S, 64'hFFFF_FFFF_89AB_CDEF},           // R7
      {3'd1, 5'h1F, 64'h24, S, 64'hFFFF_FFFF_F89A_BCDE},           // R6
      {3'd0, 5'd8,  64'h0,  64'h0000_0000_1234_5678, 64'h0000_0000_7812_3456}, // R2
      {3'd0, 5'd8,  64'h0,  64'hFFFF_0000_1234_5678, 64'h0000_0000_7812_3456}, // R3
      {3'd2, 5'd4,  64'h9,  S, 64'hF012_3456_789A_BCDE},           // R4
      {3'd3, 5'h11, 64'h44, S, 64'hF012_3456_789A_BCDE},           // R6
      {3'd3, 5'd0,  64'h20, S, 64'h89AB_CDEF_0123_4567},           // R4
      {3'd4, 5'd0,  64'h5,  S, 64'h89AB_CDEF_0123_4567},           // R5
      {3'd4, 5'd4,  64'h0,  S, 64'h789A_BCDE_F012_3456},           // R5
      {3'd2, 5'd0,  64'h3,  S, S},                                 // R7
      {3'd3, 5'd2,  64'h3F, S, 64'h0246_8ACF_1357_9BDE},           // R4
      {3'd1, 5'd3,  64'h1F, S, 64'h0000_0000_1357_9BDF},           // R6
      {3'd2, 5'd1,  64'h0,  64'h1, 64'h8000_0000_0000_0000},       // R4
      {3'd0, 5'd1,  64'h0,  64'h1, 64'hFFFF_FFFF_8000_0000},       // R2
      {3'd7, 5'd9,  64'h9,  S, S},                                 // R8
      {3'd5, 5'd3,  64'h3,  S, S}                                  // R8
   };

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0: return "R2";
         3'd1: return "R6";
         3'd2: return "R4";
         3'd3: return "R6";
         3'd4: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [2:0] o, input logic [4:0] i,
                        input logic [63:0] a, input logic [63:0] s);
      @(posedge clk);
      #1;
      op = o; imm = i; amt = a; src = s;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [63:0] exp);
      n_chk++;
      if (res !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, res, exp);
      end
   endtask

   initial begin
      op = '0; imm = '0; amt = '0; src = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", 64'h0);   // R9: all-zero inputs give zero

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][199:197], VEC[v][196:192], VEC[v][191:128], VEC[v][127:64]);
         check(tag_of(VEC[v][199:197]), VEC[v][63:0]);
      end

      // R1: each code on the same operand gives its own distinct result
      apply(3'd2, 5'd16, 64'h0, S);
      check("R1", 64'hCDEF_0123_4567_89AB);

      // R2: sweep of single-bit word rotates, sign set only when bit lands at 31
      for (int k = 0; k < 32; k++) begin
         logic [31:0] w;
         w = 32'h1 << ((32 - k) % 32);
         apply(3'd0, k[4:0], 64'h0, 64'h1);
         check("R2", {{32{w[31]}}, w});
      end

      // R6: amt_i upper bits beyond [5:0] ignored for doubleword register form
      apply(3'd3, 5'd0, 64'hFFFF_FFFF_FFFF_FFC0, S);
      check("R6", S);

      // R9: return to zero inputs, output follows with no memory
      apply(3'd0, 5'd0, 64'h0, 64'h0);
      check("R9", 64'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule